// File: doc/BRIEF.md
# Configurable GPIO Port Bank

This block is one 8-pin general-purpose I/O port that software sets up through a byte-wide register interface. Each pin has a direction bit, a stored data bit and a polarity-inversion bit. One port-wide bit chooses push-pull or open-drain drive. A 2-bit function code decides whether the pins belong to this GPIO logic or to an alternate function. When the code is not GPIO, the port turns off all of its output enables. The alternate function logic lies outside this block.

The pad side has three vectors: the level the pin would drive, a per-pin output enable, and the sampled pad input. Register reads are combinational and follow the address. Writes take effect on the next rising clock edge. The `IMPL_PINS` parameter builds a narrower port, such as a 5-pin port. Its upper pins then have no storage, read as 0 and never drive.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset, every implemented pin is an input (direction reads 1), and the data and inversion registers read 0. The port enable reads 0, the drive select is open-drain, the function code is 0 and every output enable is 0.
- R2: The registers are at these addresses. Port enable is bit 0 of 0x30. The mode register at 0x2C holds the function code in bits [1:0] and the push-pull select in bit 6; its other bits read 0. Direction is at 0xE0, data at 0xE1 and inversion at 0xE2. A write at any other address changes nothing, and a read there returns 0.
- R3: A direction bit of 1 makes its pin an input and holds its output enable at 0. A direction bit of 0 makes the pin an output.
- R4: In push-pull mode (bit 6 = 1), pad_out of each pin is data XOR inversion. The output enable is 1 for each output pin while the port is enabled and the function code is GPIO.
- R5: In open-drain mode (bit 6 = 0), pad_out is always 0. An enabled output pin asserts its output enable only while data XOR inversion is 0.
- R6: While the port enable is 0, all output enables are 0.
- R7: The function codes are 0 for IR-off, 1 for IR, 2 for GPIO and 3 for UART. Only code 2 lets the port assert any output enable.
- R8: A read of 0xE1 returns, per pin, pad input XOR inversion if the pin is an input, and the stored data bit if the pin is an output.
- R9: Pins at or above IMPL_PINS read as 0 in every per-pin register, ignore writes and keep their output enable and pad_out at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the register interface |
| reg_addr | input | ADDR_W | Register number |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for reg_addr |
| pad_in | input | PINS | Sampled pad levels |
| pad_out | output | PINS | Level presented to the pads |
| pad_oe | output | PINS | Per-pin output enable |

## Verification
On every cycle, the assertions check that no input pin, disabled port or non-GPIO function code ever asserts an output enable, and that open-drain mode never presents a high level. They also check that a write to the direction register lands in the following cycle. The bench scenarios cover the rest. These are the exact drive levels under combinations of data and inversion, the read-back merge of pad inputs with stored data, ignored writes to unknown addresses and to unimplemented pins, and the reset values. A cycle-accurate model checks each of these on a full 8-pin port and on a 5-pin port.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    FN_IR_OFF = 2'd0,
    FN_IR     = 2'd1,
    FN_GPIO   = 2'd2,
    FN_UART   = 2'd3
  } pin_fn_e;

  // level a pin presents when driven
  function automatic logic pin_level(input logic dat, input logic inv);
    return dat ^ inv;
  endfunction

  // value returned for one pin by a data-register read
  function automatic logic pin_readback(input logic is_in, input logic dat,
                                        input logic inv, input logic pad);
    return is_in ? (pad ^ inv) : dat;
  endfunction

  // the GPIO logic owns the pads only under the GPIO function code
  function automatic logic fn_owns_pins(input pin_fn_e fs);
    return fs == FN_GPIO;
  endfunction

endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_bank_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int IMPL_PINS = 8,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] A_ENABLE = 8'h30,
  parameter logic [ADDR_W-1:0] A_MODE   = 8'h2C,
  parameter logic [ADDR_W-1:0] A_DIR    = 8'hE0,
  parameter logic [ADDR_W-1:0] A_DATA   = 8'hE1,
  parameter logic [ADDR_W-1:0] A_INV    = 8'hE2,
  parameter int EN_BIT = 0,
  parameter int PP_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [PINS-1:0]   dir_q,
  output logic [PINS-1:0]   dat_q,
  output logic [PINS-1:0]   inv_q,
  output logic              en_q,
  output logic              pp_q,
  output pin_fn_e           fsel_q
);

  logic wr_dir, wr_dat, wr_inv, wr_enable, wr_mode;
  assign wr_dir    = wr && (addr == A_DIR);
  assign wr_dat    = wr && (addr == A_DATA);
  assign wr_inv    = wr && (addr == A_INV);
  assign wr_enable = wr && (addr == A_ENABLE);
  assign wr_mode   = wr && (addr == A_MODE);

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i < IMPL_PINS) begin : g_impl
      logic dir_r, dat_r, inv_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_r <= 1'b1;
          dat_r <= 1'b0;
          inv_r <= 1'b0;
        end else begin
          if (wr_dir) dir_r <= wdata[i];
          if (wr_dat) dat_r <= wdata[i];
          if (wr_inv) inv_r <= wdata[i];
        end
      end
      assign dir_q[i] = dir_r;
      assign dat_q[i] = dat_r;
      assign inv_q[i] = inv_r;

      AST_DIR_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> (dir_r == $past(wdata[i]))); // R2
    end else begin : g_absent
      assign dir_q[i] = 1'b0;
      assign dat_q[i] = 1'b0;
      assign inv_q[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pp_q   <= 1'b0;
      fsel_q <= FN_IR_OFF;
    end else begin
      if (wr_enable) en_q <= wdata[EN_BIT];
      if (wr_mode) begin
        pp_q   <= wdata[PP_BIT];
        fsel_q <= pin_fn_e'(wdata[1:0]);
      end
    end
  end

  AST_MODE_HOLDS_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(pp_q)); // R2

endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
  import gpio_bank_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int IMPL_PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] dir_q,
  input  logic [PINS-1:0] dat_q,
  input  logic [PINS-1:0] inv_q,
  input  logic            en_q,
  input  logic            pp_q,
  input  pin_fn_e         fsel_q,
  output logic [PINS-1:0] pad_out,
  output logic [PINS-1:0] pad_oe
);

  logic port_live;
  assign port_live = en_q && fn_owns_pins(fsel_q);

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i < IMPL_PINS) begin : g_impl
      logic lvl, wants_out;
      assign lvl       = pin_level(dat_q[i], inv_q[i]);
      assign wants_out = port_live && !dir_q[i];
      assign pad_out[i] = pp_q ? lvl : 1'b0;
      assign pad_oe[i]  = pp_q ? wants_out : (wants_out && !lvl);
    end else begin : g_absent
      assign pad_out[i] = 1'b0;
      assign pad_oe[i]  = 1'b0;
    end
  end

  AST_OE_ONLY_FOR_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_q) == '0); // R3
  AST_OE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> pad_oe == '0); // R6
  AST_OE_NEEDS_GPIO_FN: assert property (@(posedge clk) disable iff (!rst_n)
    (fsel_q != FN_GPIO) |-> pad_oe == '0); // R7
  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !pp_q |-> pad_out == '0); // R5

endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_bank_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int IMPL_PINS = 8,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] A_ENABLE = 8'h30,
  parameter logic [ADDR_W-1:0] A_MODE   = 8'h2C,
  parameter logic [ADDR_W-1:0] A_DIR    = 8'hE0,
  parameter logic [ADDR_W-1:0] A_DATA   = 8'hE1,
  parameter logic [ADDR_W-1:0] A_INV    = 8'hE2,
  parameter int EN_BIT = 0,
  parameter int PP_BIT = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [PINS-1:0]   dir_q,
  input  logic [PINS-1:0]   dat_q,
  input  logic [PINS-1:0]   inv_q,
  input  logic              en_q,
  input  logic              pp_q,
  input  pin_fn_e           fsel_q,
  input  logic [PINS-1:0]   pad_in,
  output logic [REG_W-1:0]  rdata
);

  logic [PINS-1:0] merged;
  logic unused_pad;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    if (i < IMPL_PINS) begin : g_impl
      assign merged[i] = pin_readback(dir_q[i], dat_q[i], inv_q[i], pad_in[i]);
    end else begin : g_absent
      assign merged[i] = 1'b0;
    end
  end
  assign unused_pad = ^pad_in;

  always_comb begin
    rdata = '0;
    if (addr == A_ENABLE) begin
      rdata[EN_BIT] = en_q;
    end else if (addr == A_MODE) begin
      rdata[1:0]    = fsel_q;
      rdata[PP_BIT] = pp_q;
    end else if (addr == A_DIR) begin
      rdata[PINS-1:0] = dir_q;
    end else if (addr == A_DATA) begin
      rdata[PINS-1:0] = merged;
    end else if (addr == A_INV) begin
      rdata[PINS-1:0] = inv_q;
    end
  end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
  import gpio_bank_pkg::*;
#(
  parameter int PINS      = 8,
  parameter int IMPL_PINS = 8,
  parameter int REG_W     = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] A_ENABLE = 8'h30,
  parameter logic [ADDR_W-1:0] A_MODE   = 8'h2C,
  parameter logic [ADDR_W-1:0] A_DIR    = 8'hE0,
  parameter logic [ADDR_W-1:0] A_DATA   = 8'hE1,
  parameter logic [ADDR_W-1:0] A_INV    = 8'hE2,
  parameter int EN_BIT = 0,
  parameter int PP_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe
);

  logic [PINS-1:0] dir_q, dat_q, inv_q;
  logic            en_q, pp_q;
  pin_fn_e         fsel_q;

  gpio_cfg_regs #(
    .PINS(PINS), .IMPL_PINS(IMPL_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .A_ENABLE(A_ENABLE), .A_MODE(A_MODE), .A_DIR(A_DIR), .A_DATA(A_DATA),
    .A_INV(A_INV), .EN_BIT(EN_BIT), .PP_BIT(PP_BIT)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .dir_q(dir_q), .dat_q(dat_q), .inv_q(inv_q),
    .en_q(en_q), .pp_q(pp_q), .fsel_q(fsel_q)
  );

  gpio_pin_drive #(.PINS(PINS), .IMPL_PINS(IMPL_PINS)) u_drive (
    .clk(clk), .rst_n(rst_n),
    .dir_q(dir_q), .dat_q(dat_q), .inv_q(inv_q),
    .en_q(en_q), .pp_q(pp_q), .fsel_q(fsel_q),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  gpio_read_mux #(
    .PINS(PINS), .IMPL_PINS(IMPL_PINS), .REG_W(REG_W), .ADDR_W(ADDR_W),
    .A_ENABLE(A_ENABLE), .A_MODE(A_MODE), .A_DIR(A_DIR), .A_DATA(A_DATA),
    .A_INV(A_INV), .EN_BIT(EN_BIT), .PP_BIT(PP_BIT)
  ) u_rmux (
    .addr(reg_addr),
    .dir_q(dir_q), .dat_q(dat_q), .inv_q(inv_q),
    .en_q(en_q), .pp_q(pp_q), .fsel_q(fsel_q),
    .pad_in(pad_in), .rdata(reg_rdata)
  );

  AST_RESET_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pad_oe == '0); // R1

endmodule

// File: tb/sim_gpio_port_bank.sv
`timescale 1ns/1ps
module sim_gpio_port_bank;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] pins = 8'h00;
  logic [7:0] rd0, po0, oe0, rd1, po1, oe1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_port_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rd0), .pad_in(pins), .pad_out(po0), .pad_oe(oe0)
  );

  gpio_port_bank #(.IMPL_PINS(5)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rd1), .pad_in(pins), .pad_out(po1), .pad_oe(oe1)
  );

  // behavioural reference: one state set per instance
  int         impl [2] = '{8, 5};
  logic [7:0] m_dir [2], m_dat [2], m_inv [2];
  bit         m_en [2], m_pp [2];
  int         m_fs [2];

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_dir[k] = 8'h00;
      for (int p = 0; p < impl[k]; p++) m_dir[k][p] = 1'b1;
      m_dat[k] = 8'h00; m_inv[k] = 8'h00;
      m_en[k] = 0; m_pp[k] = 0; m_fs[k] = 0;
    end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    for (int k = 0; k < 2; k++) begin
      case (a)
        8'h30: m_en[k] = d[0];
        8'h2C: begin m_fs[k] = int'(d[1:0]); m_pp[k] = d[6]; end
        8'hE0, 8'hE1, 8'hE2:
          for (int p = 0; p < impl[k]; p++) begin
            if (a == 8'hE0) m_dir[k][p] = d[p];
            else if (a == 8'hE1) m_dat[k][p] = d[p];
            else m_inv[k][p] = d[p];
          end
        default: ;
      endcase
    end
  endtask

  function automatic logic [7:0] exp_out(input int k);
    logic [7:0] r = 8'h00;
    for (int p = 0; p < impl[k]; p++)
      if (m_pp[k]) r[p] = m_dat[k][p] != m_inv[k][p];
    return r;
  endfunction

  function automatic logic [7:0] exp_oe(input int k);
    logic [7:0] r = 8'h00;
    bit live = m_en[k] && (m_fs[k] == 2);
    for (int p = 0; p < impl[k]; p++) begin
      bit high = m_dat[k][p] != m_inv[k][p];
      if (live && !m_dir[k][p]) r[p] = m_pp[k] ? 1'b1 : !high;
    end
    return r;
  endfunction

  function automatic logic [7:0] exp_rd(input int k, input logic [7:0] a,
                                        input logic [7:0] pad);
    logic [7:0] r = 8'h00;
    case (a)
      8'h30: r[0] = m_en[k];
      8'h2C: begin r[1:0] = m_fs[k][1:0]; r[6] = m_pp[k]; end
      8'hE0: r = m_dir[k];
      8'hE2: r = m_inv[k];
      8'hE1:
        for (int p = 0; p < impl[k]; p++)
          r[p] = m_dir[k][p] ? (pad[p] ^ m_inv[k][p]) : m_dat[k][p];
      default: r = 8'h00;
    endcase
    return r;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h at %0t", tag, what, got, exp, $time);
    end
  endtask

  // one cycle: apply inputs away from the edge, compare, then commit on the edge
  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d,
                      input logic [7:0] pad, input string tag);
    @(negedge clk);
    wr = w; addr = a; wdata = d; pins = pad;
    #1;
    check(tag, "u0 rdata", rd0, exp_rd(0, a, pad));
    check(tag, "u0 pad_out", po0, exp_out(0));
    check(tag, "u0 pad_oe", oe0, exp_oe(0));
    check(tag, "u1 rdata", rd1, exp_rd(1, a, pad));
    check(tag, "u1 pad_out", po1, exp_out(1));
    check(tag, "u1 pad_oe", oe1, exp_oe(1));
    @(posedge clk);
    if (w && rst_n) model_write(a, d);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: all requirements, actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    model_reset();
    // R1: reset values while reset is held and just after
    step(0, 8'hE0, 8'h00, 8'h00, "R1");
    step(0, 8'h2C, 8'h00, 8'h00, "R1");
    rst_n = 1'b1;
    step(0, 8'hE0, 8'h00, 8'h00, "R1");
    step(0, 8'hE2, 8'h00, 8'h00, "R1");
    step(0, 8'h30, 8'h00, 8'h00, "R1");
    step(0, 8'h2C, 8'h00, 8'h00, "R1");

    // R2: read back and unknown addresses
    step(1, 8'hE2, 8'h33, 8'h00, "R2");
    step(0, 8'hE2, 8'h00, 8'h00, "R2");
    step(1, 8'h2C, 8'hC1, 8'h00, "R2");
    step(0, 8'h2C, 8'h00, 8'h00, "R2");
    step(1, 8'h30, 8'hFE, 8'h00, "R2");
    step(0, 8'h30, 8'h00, 8'h00, "R2");
    step(1, 8'h55, 8'hFF, 8'h00, "R2");
    step(0, 8'h55, 8'h00, 8'h00, "R2");
    step(1, 8'hE3, 8'hFF, 8'h00, "R2");
    step(0, 8'hE2, 8'h00, 8'h00, "R2");
    step(1, 8'hE2, 8'h00, 8'h00, "R2");

    // R6: outputs configured, GPIO code, push-pull, but port disabled
    step(1, 8'hE0, 8'h00, 8'h00, "R6");
    step(1, 8'h2C, 8'h42, 8'h00, "R6");
    step(1, 8'hE1, 8'hA5, 8'h00, "R6");
    step(0, 8'hE1, 8'h00, 8'h00, "R6");

    // R4: enable in push-pull, several data/inversion patterns
    step(1, 8'h30, 8'h01, 8'h00, "R4");
    step(0, 8'hE1, 8'h00, 8'h00, "R4");
    step(1, 8'hE2, 8'h0F, 8'h00, "R4");
    step(0, 8'hE1, 8'h00, 8'hFF, "R4");
    step(1, 8'hE1, 8'h3C, 8'h00, "R4");
    step(0, 8'h2C, 8'h00, 8'h00, "R4");

    // R3: half inputs, half outputs
    step(1, 8'hE0, 8'hF0, 8'h00, "R3");
    step(0, 8'hE0, 8'h00, 8'h00, "R3");
    step(1, 8'hE0, 8'h0F, 8'h00, "R3");

    // R5: open-drain
    step(1, 8'h2C, 8'h02, 8'h00, "R5");
    step(1, 8'hE0, 8'h00, 8'h00, "R5");
    step(1, 8'hE1, 8'h96, 8'h00, "R5");
    step(1, 8'hE2, 8'hFF, 8'h00, "R5");
    step(1, 8'hE2, 8'h00, 8'h00, "R5");

    // R7: each non-GPIO code removes the pins, then GPIO again
    step(1, 8'h2C, 8'h40, 8'h00, "R7");
    step(0, 8'h2C, 8'h00, 8'h00, "R7");
    step(1, 8'h2C, 8'h41, 8'h00, "R7");
    step(1, 8'h2C, 8'h43, 8'h00, "R7");
    step(0, 8'h2C, 8'h00, 8'h00, "R7");
    step(1, 8'h2C, 8'h42, 8'h00, "R7");

    // R8: data read-back merges pad inputs and stored data
    step(1, 8'hE0, 8'hCC, 8'h00, "R8");
    step(1, 8'hE1, 8'h5A, 8'h00, "R8");
    step(0, 8'hE1, 8'h00, 8'hF0, "R8");
    step(0, 8'hE1, 8'h00, 8'h0F, "R8");
    step(1, 8'hE2, 8'hA0, 8'h69, "R8");
    step(0, 8'hE1, 8'h00, 8'h69, "R8");
    step(0, 8'hE1, 8'h00, 8'h96, "R8");

    // R9: all-ones writes reach only implemented pins
    step(1, 8'hE0, 8'h00, 8'h00, "R9");
    step(1, 8'hE1, 8'hFF, 8'h00, "R9");
    step(1, 8'hE2, 8'hE0, 8'h00, "R9");
    step(0, 8'hE1, 8'h00, 8'hFF, "R9");
    step(0, 8'hE2, 8'h00, 8'hFF, "R9");
    step(1, 8'hE0, 8'hFF, 8'hFF, "R9");
    step(0, 8'hE1, 8'h00, 8'hFF, "R9");
    step(0, 8'hE0, 8'h00, 8'h00, "R9");

    done = 1;
    summary();
    $finish;
  end

endmodule